// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a countdown watchdog that sits on a simple register bus with 16-bit data. A slow-clock tick enable drives a divider. The divider produces one time unit, nominally 10 ms, every `TICK_DIV` slow ticks. While the timer runs, the counter drops by one on each unit. Each control action takes effect only when it carries a specific key value:

- feed,
- resume,
- clearing the timed-out status,
- the two-step disable.

One unit before expiry the block raises a pre-warning event. The event can drive an interrupt. At expiry the block emits a one-cycle system reset pulse and records a timed-out code. It then reloads the last programmed timeout and keeps counting.

Bus accesses complete in the cycle they are presented, and the block never applies back-pressure. A write happens on the clock edge where `bus_sel_i` and `bus_wr_i` are both high. Read data is a combinational decode of `bus_addr_i`, so it is valid in the same cycle. A debug-mode input pauses the counter unless software has set the run-in-debug bit. Out of reset the timer is disabled, the interrupt mask is clear, and the count and timeout hold `DEF_TMO`.

Top module: `wdg_keyed`

## Requirements

Byte addresses and reset/normal states:

- R1: After reset:
  - the disable2 register (0x0C) reads 0xDABE,
  - status (0x10) reads 0x0000,
  - mask (0x24) reads 0,
  - count (0x14) reads `DEF_TMO`,
  - `irq_o` and `sys_rst_o` are 0.

Feeding and timeout:

- R2: Writing 0xFEED to address 0x00 reloads the counter from the timeout register. Any other value written there leaves the count unchanged.
- R3: A write to 0x04 stores bits 14:0 of the data as the timeout in units. A read of 0x04 returns it with bit 15 at 0.
- R4: While the timer is enabled and not paused, the count falls by one for every `TICK_DIV` slow-tick pulses. While the timer is disabled, slow ticks leave the count unchanged.

Enable and disable:

- R5: The timer is disabled by writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C, with the second write being the very next bus write. A 0xCAFE write without that immediately preceding key is ignored. Address 0x0C reads 0xDABE while the timer is disabled and 0x0000 while it is enabled.
- R6: Writing 0xACED to 0x1C enables the timer. Other values written there are ignored.

Expiry and status:

- R7: When a unit arrives with the count at 1, the block does three things in the following cycle:
  - `sys_rst_o` is high for exactly that one cycle,
  - status reads 0xCFE8,
  - the count equals the timeout.
  The timer stays enabled.
- R8: Writing 0xE8B4 to 0x10 returns status to 0x0000. Any other value written there is ignored.

Count readout:

- R9: Address 0x14 returns the count in bits 14:0. Bit 15 is 1 during the single cycle that follows a change of the count, and 0 otherwise.

Pre-warning interrupt:

- R10: The pre-warning event behaves as follows:
  - It sits in bit 0 of 0x20 and is set when the count steps from 2 to 1.
  - Writing 1 to bit 0 of 0x20 clears it.
  - While bit 0 of 0x28 is 1, the event is held set.
  - `irq_o` equals the event ANDed with bit 0 of 0x24.

Debug override:

- R11: Address 0x18 reads `dbg_mode_i` in bit 1 and the run-in-debug bit in bit 0; bit 0 is written through bit 0. While `dbg_mode_i` is 1 and the run-in-debug bit is 0, slow ticks leave the count unchanged.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle enable from the slow clock domain |
| dbg_mode_i | input | 1 | High while the debugger holds the system |
| bus_sel_i | input | 1 | Access strobe |
| bus_wr_i | input | 1 | Access is a write when high |
| bus_addr_i | input | 6 | Byte address of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Pre-warning interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request at expiry |

## Verification

The bench targets several corner cases, each tied to a specific wrong design:

- **Disable sequence.** It attempts to break the two-key disable with an unrelated write between the keys, and with a lone second key. A design that remembers the first key across other writes would stop the timer when it should not.
- **Expiry cycle.** It checks the exact expiry cycle. A design that reloads zero, or leaves the reset pulse high for longer than one cycle, is caught there.
- **Forced event.** It acknowledges the event while the force bit is set. A design that lets the acknowledge win would drop an event that is being injected.
- **Debug pause.** It ticks with debug active and the override both set and clear. A design that ignores the override would either keep running or stop.
- **Count stability.** It samples the count read in the cycle right after a unit tick, where bit 15 must be set.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [5:0] A_FEED  = 6'h00;
  localparam logic [5:0] A_TMO   = 6'h04;
  localparam logic [5:0] A_DIS1  = 6'h08;
  localparam logic [5:0] A_DIS2  = 6'h0C;
  localparam logic [5:0] A_STAT  = 6'h10;
  localparam logic [5:0] A_CNT   = 6'h14;
  localparam logic [5:0] A_DBG   = 6'h18;
  localparam logic [5:0] A_RSM   = 6'h1C;
  localparam logic [5:0] A_EVT   = 6'h20;
  localparam logic [5:0] A_MASK  = 6'h24;
  localparam logic [5:0] A_FORCE = 6'h28;

  localparam logic [15:0] K_FEED    = 16'hFEED;
  localparam logic [15:0] K_DIS1    = 16'h2BAD;
  localparam logic [15:0] K_DIS2    = 16'hCAFE;
  localparam logic [15:0] K_RESUME  = 16'hACED;
  localparam logic [15:0] K_CLEAR   = 16'hE8B4;
  localparam logic [15:0] C_OFF     = 16'hDABE;
  localparam logic [15:0] C_TIMEOUT = 16'hCFE8;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int TICK_DIV = 328
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_tick_i,
  input  logic run_i,
  output logic unit_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign unit_o = slow_tick_i && run_i && (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (slow_tick_i && run_i) begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int DEF_TMO = 6000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  input  logic [5:0]       bus_addr_i,
  input  logic [15:0]      bus_wdata_i,
  input  logic             expire_i,
  output logic             en_o,
  output logic             tout_o,
  output logic [CNT_W-1:0] tmo_o,
  output logic             mask_o,
  output logic             force_o,
  output logic             keep_o,
  output logic             feed_o,
  output logic             ack_o
);
  logic wr;
  logic armed_q;

  assign wr     = bus_sel_i && bus_wr_i;
  assign feed_o = wr && (bus_addr_i == A_FEED) && (bus_wdata_i == K_FEED);
  assign ack_o  = wr && (bus_addr_i == A_EVT) && bus_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      en_o    <= 1'b0;
      tout_o  <= 1'b0;
      tmo_o   <= CNT_W'(DEF_TMO);
      mask_o  <= 1'b0;
      force_o <= 1'b0;
      keep_o  <= 1'b0;
    end else begin
      if (wr) begin
        // only the write directly after the first key keeps the sequence armed
        armed_q <= (bus_addr_i == A_DIS1) && (bus_wdata_i == K_DIS1);
        unique case (bus_addr_i)
          A_TMO:   tmo_o   <= bus_wdata_i[CNT_W-1:0];
          A_DIS2:  if (armed_q && bus_wdata_i == K_DIS2) en_o <= 1'b0;
          A_RSM:   if (bus_wdata_i == K_RESUME) en_o <= 1'b1;
          A_MASK:  mask_o  <= bus_wdata_i[0];
          A_FORCE: force_o <= bus_wdata_i[0];
          A_DBG:   keep_o  <= bus_wdata_i[0];
          default: ;
        endcase
      end
      // expiry takes priority over a clear in the same cycle
      if (expire_i) begin
        tout_o <= 1'b1;
      end else if (wr && bus_addr_i == A_STAT && bus_wdata_i == K_CLEAR) begin
        tout_o <= 1'b0;
      end
    end
  end

  p_disable_keyed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o) |-> $past(armed_q));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int CNT_W   = 15,
  parameter int DEF_TMO = 6000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             unit_i,
  input  logic             feed_i,
  input  logic             ack_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             evt_o,
  output logic             expire_o,
  output logic             sys_rst_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] view_q;
  logic             step;

  assign step     = unit_i && !feed_i;
  assign expire_o = step && (cnt_o <= ONE);
  assign busy_o   = (view_q != cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= CNT_W'(DEF_TMO);
      view_q    <= CNT_W'(DEF_TMO);
      evt_o     <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      view_q    <= cnt_o;
      sys_rst_o <= expire_o;
      if (feed_i || expire_o) begin
        cnt_o <= tmo_i;
      end else if (step) begin
        cnt_o <= cnt_o - 1'b1;
      end
      if (force_i) begin
        evt_o <= 1'b1;
      end else if (ack_i || expire_o) begin
        evt_o <= 1'b0;
      end else if (step && cnt_o == TWO) begin
        evt_o <= 1'b1;
      end
    end
  end

  p_event_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> ($past(force_i) || $past(cnt_o) == TWO));
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int TICK_DIV = 328,
  parameter int DEF_TMO  = 6000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_tick_i,
  input  logic        dbg_mode_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [5:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        irq_o,
  output logic        sys_rst_o
);
  logic             en, tout, mask, frc, keep, feed, ack;
  logic             run, unit, busy, evt, expire;
  logic [CNT_W-1:0] tmo, cnt;

  assign run   = en && (!dbg_mode_i || keep);
  assign irq_o = evt && mask;

  wdg_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_tick_i(slow_tick_i),
    .run_i(run), .unit_o(unit)
  );

  wdg_ctrl #(.CNT_W(CNT_W), .DEF_TMO(DEF_TMO)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .expire_i(expire),
    .en_o(en), .tout_o(tout), .tmo_o(tmo), .mask_o(mask), .force_o(frc),
    .keep_o(keep), .feed_o(feed), .ack_o(ack)
  );

  wdg_countdown #(.CNT_W(CNT_W), .DEF_TMO(DEF_TMO)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .unit_i(unit), .feed_i(feed), .ack_i(ack),
    .force_i(frc), .tmo_i(tmo), .cnt_o(cnt), .busy_o(busy), .evt_o(evt),
    .expire_o(expire), .sys_rst_o(sys_rst_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      A_TMO:   bus_rdata_o = 16'(tmo);
      A_DIS2:  bus_rdata_o = en ? 16'h0000 : C_OFF;
      A_STAT:  bus_rdata_o = tout ? C_TIMEOUT : 16'h0000;
      A_CNT:   bus_rdata_o = 16'(cnt) | (busy ? 16'h8000 : 16'h0000);
      A_DBG:   bus_rdata_o = {14'b0, dbg_mode_i, keep};
      A_EVT:   bus_rdata_o = {15'b0, evt};
      A_MASK:  bus_rdata_o = {15'b0, mask};
      A_FORCE: bus_rdata_o = {15'b0, frc};
      default: bus_rdata_o = 16'h0000;
    endcase
  end

  p_halt_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !feed) |=> $stable(cnt));
  p_pulse_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> tout);
  p_pulse_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (cnt == $past(tmo)));
endmodule

// File: tb/tb_wdg_keyed.sv
module tb_wdg_keyed;
  localparam int TB_DIV = 2;
  localparam int TB_TMO = 10;
  localparam int NV     = 29;

  logic        clk = 1'b0, rst_n = 1'b0, slow = 1'b0, dbg = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, rv;
  logic        irq, srst;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  wdg_keyed #(.CNT_W(15), .TICK_DIV(TB_DIV), .DEF_TMO(TB_TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .dbg_mode_i(dbg),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  // {write, addr, data/expected, requirement number}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 6'h0C, 16'hDABE, 4'd1},   // R1 disabled
    {1'b0, 6'h10, 16'h0000, 4'd1},   // R1 status normal
    {1'b0, 6'h24, 16'h0000, 4'd1},   // R1 mask clear
    {1'b0, 6'h14, 16'h000A, 4'd1},   // R1 default count
    {1'b1, 6'h04, 16'h8005, 4'd3},
    {1'b0, 6'h04, 16'h0005, 4'd3},   // R3 bit 15 dropped
    {1'b1, 6'h00, 16'h1234, 4'd2},
    {1'b0, 6'h14, 16'h000A, 4'd2},   // R2 bad feed ignored
    {1'b1, 6'h00, 16'hFEED, 4'd2},
    {1'b0, 6'h14, 16'h0005, 4'd2},   // R2 reload
    {1'b1, 6'h1C, 16'h1111, 4'd6},
    {1'b0, 6'h0C, 16'hDABE, 4'd6},   // R6 bad resume ignored
    {1'b1, 6'h1C, 16'hACED, 4'd6},
    {1'b0, 6'h0C, 16'h0000, 4'd6},   // R6 enabled
    {1'b1, 6'h0C, 16'hCAFE, 4'd5},
    {1'b0, 6'h0C, 16'h0000, 4'd5},   // R5 lone key ignored
    {1'b1, 6'h08, 16'h2BAD, 4'd5},
    {1'b1, 6'h24, 16'h0001, 4'd5},
    {1'b1, 6'h0C, 16'hCAFE, 4'd5},
    {1'b0, 6'h0C, 16'h0000, 4'd5},   // R5 broken sequence ignored
    {1'b1, 6'h08, 16'h2BAD, 4'd5},
    {1'b1, 6'h0C, 16'hCAFE, 4'd5},
    {1'b0, 6'h0C, 16'hDABE, 4'd5},   // R5 disabled
    {1'b1, 6'h10, 16'h1234, 4'd8},
    {1'b0, 6'h10, 16'h0000, 4'd8},   // R8 bad clear ignored
    {1'b0, 6'h24, 16'h0001, 4'd10},  // R10 mask written
    {1'b0, 6'h18, 16'h0000, 4'd11},
    {1'b1, 6'h18, 16'h0001, 4'd11},
    {1'b0, 6'h18, 16'h0001, 4'd11}   // R11 run-in-debug set
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic slow_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow = 1'b1;
      @(negedge clk); slow = 1'b0;
    end
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 sys_rst", {15'b0, srst}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) bus_wr(VEC[i][25:20], VEC[i][19:4]);
      else begin
        bus_rd(VEC[i][25:20], rv);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rv, VEC[i][19:4]);
      end
    end

    // R4: disabled timer ignores slow ticks
    slow_pulses(4);
    bus_rd(6'h14, rv); check("R4 frozen when disabled", rv, 16'h0005);

    // R9: unstable indicator right after a unit step
    bus_wr(6'h1C, 16'hACED);
    addr = 6'h14;
    slow_pulses(2);
    check("R9 busy after step", rdata, 16'h8004);
    @(negedge clk); #1;
    check("R9 stable next cycle", rdata, 16'h0004);

    // R10: pre-warning at count 1
    slow_pulses(4);
    check("R10 no early irq", {15'b0, irq}, 16'h0);
    slow_pulses(2);
    check("R10 irq at count one", {15'b0, irq}, 16'h1);
    bus_rd(6'h20, rv); check("R10 event bit", rv, 16'h0001);
    bus_wr(6'h20, 16'h0001);
    bus_rd(6'h20, rv); check("R10 ack clears", rv, 16'h0000);
    check("R10 irq dropped", {15'b0, irq}, 16'h0);

    // R7: expiry
    slow_pulses(2);
    check("R7 pulse high", {15'b0, srst}, 16'h1);
    @(negedge clk); #1;
    check("R7 pulse one cycle", {15'b0, srst}, 16'h0);
    bus_rd(6'h10, rv); check("R7 status code", rv, 16'hCFE8);
    bus_rd(6'h14, rv); check("R7 reload", rv, 16'h0005);
    bus_rd(6'h0C, rv); check("R7 keeps running", rv, 16'h0000);

    // R8: status clear
    bus_wr(6'h10, 16'hE8B5);
    bus_rd(6'h10, rv); check("R8 wrong key", rv, 16'hCFE8);
    bus_wr(6'h10, 16'hE8B4);
    bus_rd(6'h10, rv); check("R8 cleared", rv, 16'h0000);

    // R10: force and mask
    bus_wr(6'h28, 16'h0001);
    bus_rd(6'h20, rv); check("R10 forced event", rv, 16'h0001);
    check("R10 forced irq", {15'b0, irq}, 16'h1);
    bus_wr(6'h20, 16'h0001);
    bus_rd(6'h20, rv); check("R10 force beats ack", rv, 16'h0001);
    bus_wr(6'h24, 16'h0000);
    #1 check("R10 masked irq", {15'b0, irq}, 16'h0);
    bus_wr(6'h28, 16'h0000);
    bus_wr(6'h20, 16'h0001);
    bus_rd(6'h20, rv); check("R10 cleared after force", rv, 16'h0000);
    bus_wr(6'h24, 16'h0001);

    // R11: debug override
    dbg = 1'b1;
    bus_rd(6'h18, rv); check("R11 debug read", rv, 16'h0003);
    slow_pulses(2);
    bus_rd(6'h14, rv); check("R11 runs with override", rv, 16'h0004);
    bus_wr(6'h18, 16'h0000);
    slow_pulses(4);
    bus_rd(6'h14, rv); check("R11 paused in debug", rv, 16'h0004);
    bus_rd(6'h18, rv); check("R11 indicator only", rv, 16'h0002);
    dbg = 1'b0;
    slow_pulses(2);
    bus_rd(6'h14, rv); check("R11 resumes", rv, 16'h0003);

    // R2/R3: feed with a new timeout while running
    bus_wr(6'h04, 16'h0100);
    bus_wr(6'h00, 16'hFEED);
    bus_rd(6'h14, rv); check("R2 feed new timeout", rv, 16'h0100);

    finish_run();
  end
endmodule